// File: doc/BRIEF.md
# Prioritised interrupt level sampler

This block decides, at discrete sampling points, whether a processor core should take a hardware interrupt trap. Each core sees a vector of pending interrupt lines. The block picks the most urgent line, which is the highest-numbered line that is set. Line 0 is never a request. The block compares that line's level with the core's current interrupt mask level. It also checks whether traps are enabled. When both checks pass, it raises an inject pulse and presents the level and the trap type that the core's trap logic will vector on.

Sampling is not continuous. The surrounding runtime or pipeline pulses a sample strobe once before each execution slice, and the block evaluates the inputs only on that strobe. The block keeps no memory of requests it declined. A declined line stays asserted at its source, so it is simply evaluated again at the next sample. It is taken once the mask level falls far enough, and it stops mattering once software clears it at the source.

Top module: `irq_level_sampler`

## Requirements
- R1: The candidate level is the index of the highest set bit of `pend_i`. Only bits 1 through NLINES-1 are considered, so bit 0 never produces a candidate.
- R2: An injection happens only when the candidate level is strictly greater than `pil_i`. A candidate equal to `pil_i` is not taken.
- R3: No injection happens when `et_i` is 0 at the sample, whatever the other inputs are.
- R4: When an injection is made, `ttype_o` equals TT_BASE (0x10 by default) plus the level. When a sample makes no injection, `ttype_o` is 0.
- R5: When no bit from 1 to NLINES-1 is set at a sample, `inject_o` stays low and `level_o` is 0.
- R6: The outputs are registered, and they reflect a sample on the clock edge where `sample_i` is high. `inject_o` is high for exactly that one following cycle.
- R7: Between samples, `level_o` and `ttype_o` hold their values and `inject_o` is low, whatever the inputs do.
- R8: A declined request is not stored. The next sample decides only from the inputs present at that sample. A lowered `pil_i` lets the request through, and a cleared line is no longer taken.
- R9: Level 15 goes through the same comparison, so it is never injected while `pil_i` is 15.
- R10: After reset, `inject_o`, `level_o` and `ttype_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Sampling point strobe |
| pend_i | input | NLINES | Pending interrupt lines, bit n is level n |
| pil_i | input | LVLW | Current processor interrupt level (mask) |
| et_i | input | 1 | Trap enable bit |
| inject_o | output | 1 | One-cycle pulse: take an interrupt trap |
| level_o | output | LVLW | Candidate level from the last sample |
| ttype_o | output | TTW | Trap type of the injection, 0 when none |

## Verification
The bench builds the block with its default values: 16 lines, a 4-bit level, an 8-bit trap type and a base of 0x10. These values cover the whole level range, including the level-15 versus mask-15 corner. With them the bench can drive every mask value against every candidate, exhaustively at the boundaries and at random elsewhere. Random pending vectors with bit 0 heavily weighted show that the line-0 exclusion works. Sequences that decline a request, then lower the mask or clear the line, show that nothing is stored from one sample to the next.

// File: rtl/irq_level_sampler.sv
module irq_level_sampler #(
  parameter int NLINES  = 16,
  parameter int TTW     = 8,
  parameter int TT_BASE = 16,
  localparam int LVLW   = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [NLINES-1:0] pend_i,
  input  logic [LVLW-1:0]   pil_i,
  input  logic              et_i,
  output logic              inject_o,
  output logic [LVLW-1:0]   level_o,
  output logic [TTW-1:0]    ttype_o
);

  logic [NLINES-1:0] live;
  logic [LVLW-1:0]   cand;
  logic              take;

  assign live = pend_i & ~NLINES'(1);

  always_comb begin
    cand = '0;
    for (int i = 1; i < NLINES; i++)
      if (live[i]) cand = LVLW'(i);
  end

  assign take = et_i && (cand > pil_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inject_o <= 1'b0;
      level_o  <= '0;
      ttype_o  <= '0;
    end else begin
      inject_o <= sample_i && take;
      if (sample_i) begin
        level_o <= cand;
        ttype_o <= take ? TTW'(TT_BASE) + TTW'(cand) : '0;
      end
    end
  end

endmodule

// File: rtl/irq_level_sampler_chk.sv
module irq_level_sampler_chk #(
  parameter int NLINES  = 16,
  parameter int TTW     = 8,
  parameter int TT_BASE = 16,
  localparam int LVLW   = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_i,
  input logic [NLINES-1:0] pend_i,
  input logic [LVLW-1:0]   pil_i,
  input logic              et_i,
  input logic              inject_o,
  input logic [LVLW-1:0]   level_o,
  input logic [TTW-1:0]    ttype_o
);

  p_pulse_only_after_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> !inject_o);

  p_hold_between_samples_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> ($stable(level_o) && $stable(ttype_o)));

  p_et_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !et_i) |=> !inject_o);

  p_idle_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && pend_i[NLINES-1:1] == '0) |=> (!inject_o && level_o == '0));

  p_strict_above_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inject_o |-> (level_o > $past(pil_i)));

  p_trap_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inject_o |-> (ttype_o == TTW'(TT_BASE) + TTW'(level_o)));

  p_no_type_without_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i) |=> (inject_o || ttype_o == '0));

endmodule

bind irq_level_sampler irq_level_sampler_chk #(
  .NLINES(NLINES), .TTW(TTW), .TT_BASE(TT_BASE)
) chk_i (.*);

// File: tb/irq_level_sampler_tb_top.sv
`timescale 1ns/1ps
module irq_level_sampler_tb_top;
  localparam int NLINES = 16;
  localparam int TTW    = 8;
  localparam int TTB    = 16;
  localparam int LVLW   = $clog2(NLINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_i = 1'b0;
  logic [NLINES-1:0] pend_i = '0;
  logic [LVLW-1:0] pil_i = '0;
  logic et_i = 1'b0;
  logic inject_o;
  logic [LVLW-1:0] level_o;
  logic [TTW-1:0] ttype_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irq_level_sampler #(.NLINES(NLINES), .TTW(TTW), .TT_BASE(TTB)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .pend_i(pend_i),
    .pil_i(pil_i), .et_i(et_i), .inject_o(inject_o), .level_o(level_o),
    .ttype_o(ttype_o));

  function automatic int exp_level(logic [NLINES-1:0] p);
    for (int i = NLINES - 1; i >= 1; i--) if (p[i]) return i;
    return 0;
  endfunction

  function automatic bit exp_take(logic [NLINES-1:0] p, int pil, bit et);
    return et && (exp_level(p) > pil);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_sample(logic [NLINES-1:0] p, int pil, bit et, string req);
    int lv;
    bit tk;
    logic [LVLW-1:0] held_lv;
    logic [TTW-1:0] held_tt;
    @(negedge clk);
    pend_i = p; pil_i = LVLW'(pil); et_i = et; sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    lv = exp_level(p);
    tk = exp_take(p, pil, et);
    chk({req, " inject"}, int'(inject_o), int'(tk));
    chk({req, " level"}, int'(level_o), lv);
    chk({req, " ttype"}, int'(ttype_o), tk ? TTB + lv : 0);
    held_lv = level_o; held_tt = ttype_o;
    pend_i = NLINES'($urandom); pil_i = LVLW'($urandom); et_i = 1'($urandom);
    @(negedge clk);
    chk("R6 single-cycle pulse", int'(inject_o), 0);
    chk("R7 level held", int'(level_o), int'(held_lv));
    chk("R7 ttype held", int'(ttype_o), int'(held_tt));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 reset inject", int'(inject_o), 0);
    chk("R10 reset level", int'(level_o), 0);
    chk("R10 reset ttype", int'(ttype_o), 0);
    rst_n = 1'b1;

    do_sample(16'h0001, 0, 1'b1, "R5 line0 only");
    do_sample(16'h0000, 0, 1'b1, "R5 nothing pending");
    do_sample(16'h00A5, 0, 1'b1, "R1 highest wins");
    do_sample(16'h0081, 7, 1'b1, "R2 equal to mask");
    do_sample(16'h0081, 6, 1'b1, "R2 one above mask");
    do_sample(16'h8000, 15, 1'b1, "R9 level15 mask15");
    do_sample(16'h8000, 14, 1'b1, "R4 level15 type 0x1f");
    do_sample(16'h0002, 0, 1'b1, "R4 level1 type 0x11");
    do_sample(16'hFFFE, 0, 1'b0, "R3 traps disabled");
    do_sample(16'h0410, 12, 1'b1, "R8 declined");
    do_sample(16'h0410, 3, 1'b1, "R8 mask lowered taken");
    do_sample(16'h0400, 12, 1'b1, "R8 declined again");
    do_sample(16'h0000, 3, 1'b1, "R8 line cleared");

    for (int n = 0; n < 400; n++) begin
      logic [NLINES-1:0] p;
      p = NLINES'($urandom);
      if (($urandom % 4) == 0) p = p & NLINES'(32'h1 << ($urandom % NLINES));
      if (($urandom % 4) == 0) p[0] = 1'b1;
      do_sample(p, int'($urandom % NLINES), 1'(($urandom % 8) != 0), "R1 R2 R3 R4 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule